// File: doc/BRIEF.md
# Hyperblock Commit Controller

This block holds the results of up to four instruction blocks that execute at the same time, and writes those results to the architectural register file in program order. When a block is mapped, the controller gives it the next frame number in a circular sequence and records how many distinct register results that block will produce. A following block can be mapped while earlier ones are still running. Results reach the controller out of order. Each result carries its frame number, the destination register, its position within the block (a program-order index) and its data. The controller keeps these results in a small buffer for each frame. Nothing reaches the register file before the block commits.

A frame is complete when the number of distinct registers it holds equals its expected count. Only the oldest frame in flight may commit. The commit drains the buffer onto a single register write port at one write per cycle, then frees the frame and reports the frame number on a done pulse. An early exit resolved inside a block gives a cut-off index and a reduced expected count. Buffered and later results past the cut-off are discarded. A mispredict input releases every frame younger than a given frame, and those frames write nothing.

Top module: `hb_commit_ctrl`

## Requirements
- R1: While reset is high and at the first edge after it is released, `wr_en` and `done_valid` are 0, `map_ready` is 1 and `map_frame` is 0.
- R2: Mapped blocks receive frame numbers 0, 1, 2, 3, 0, … in turn, and `map_frame` always shows the number the next block will get. With four frames in flight, `map_ready` is 0. A map request is ignored while `map_ready` is 0, and also in a cycle where `flush_valid` is 1.
- R3: No register write for a frame occurs before the frame holds as many distinct registers as its expected count. The first write appears one clock edge after the edge that captured the completing result.
- R4: A commit produces one write per consecutive cycle, in buffer-slot order from lowest to highest. A new register takes the lowest free slot.
- R5: One edge after a frame's last write, `done_valid` pulses for one cycle with that frame's number in `done_frame`. For a frame that expects zero results, the pulse comes two edges after the map. `wr_en` is 0 in any cycle where `done_valid` is 1.
- R6: Frames commit strictly in mapping order. A complete younger frame waits until every older frame has finished its done pulse.
- R7: A result for a register already held by the same frame replaces the held data only when its index is strictly greater than the held index. Otherwise it is dropped. Either way, the count of distinct registers does not change.
- R8: An exit on a frame with cut-off k and count c discards held results with index > k, drops later results with index > k, and sets the expected count to c.
- R9: A result that arrives in the same cycle as an exit on the same frame is judged against that exit's cut-off.
- R10: A flush on a frame in flight releases every younger frame without any write, and sets `map_frame` to that frame's number plus one. The flushed frame and all older frames still commit normally.
- R11: Results addressed to a frame that is not in flight are ignored. They do not count toward a block that is later mapped to that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_valid | input | 1 | Request to map a new block |
| map_count | input | 3 | Number of distinct registers the block will produce |
| map_ready | output | 1 | A frame is free for mapping |
| map_frame | output | 2 | Frame number the next mapped block receives |
| out_valid | input | 1 | A result is presented |
| out_frame | input | 2 | Frame of the result |
| out_reg | input | 5 | Destination register number |
| out_idx | input | 5 | Program-order index of the producing instruction |
| out_data | input | 32 | Result value |
| exit_valid | input | 1 | An early exit has resolved |
| exit_frame | input | 2 | Frame containing the exit |
| exit_idx | input | 5 | Program-order index of the exit |
| exit_count | input | 3 | Expected register count that remains after the exit |
| flush_valid | input | 1 | Mispredict: release frames younger than `flush_frame` |
| flush_frame | input | 2 | Youngest frame that survives |
| wr_en | output | 1 | Register file write strobe |
| wr_reg | output | 5 | Register file write address |
| wr_data | output | 32 | Register file write data |
| done_valid | output | 1 | A frame has committed and is free |
| done_frame | output | 2 | Frame that committed |

## Verification
Two events can land on one frame in the same cycle: an arriving result and an early exit. This is the case most likely to keep a result that should be discarded, or to lose one that should be kept. The bench drives an exit together with a result whose index lies past the cut-off, and separately together with one whose index lies before it. It then judges each case by the set of register writes the frame produces and by the cycle in which the first write appears. A second collision, a done pulse for one frame while a younger complete frame waits, is provoked by completing the younger frame first. It is judged by the order of writes and done pulses.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_FRAMES = 4;
    localparam int HB_SLOTS  = 4;
    localparam int HB_REG_W  = 5;
    localparam int HB_IDX_W  = 5;
    localparam int HB_DATA_W = 32;

    localparam int HB_FID_W  = $clog2(HB_FRAMES);
    localparam int HB_CNT_W  = $clog2(HB_SLOTS + 1);

    // One buffered block result.
    typedef struct packed {
        logic [HB_REG_W-1:0]  rnum;
        logic [HB_IDX_W-1:0]  pidx;
        logic [HB_DATA_W-1:0] val;
    } hb_out_t;

endpackage

// File: rtl/hb_pick_low.sv
// Lowest-set-bit picker used for free-slot allocation and drain order.
module hb_pick_low #(
    parameter  int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                sel = W'(i);
            end
        end
    end
endmodule

// File: rtl/hb_frame_buf.sv
// Result buffer and completion count for one frame.
module hb_frame_buf import hb_pkg::*; #(
    parameter  int NSLOT = HB_SLOTS,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc,
    input  logic [CW-1:0]       alloc_cnt,
    input  logic                kill,
    input  logic                freeze,
    input  logic                out_hit,
    input  hb_out_t             out_body,
    input  logic                exit_hit,
    input  logic [HB_IDX_W-1:0] exit_k,
    input  logic [CW-1:0]       exit_cnt,
    input  logic                pop,
    input  logic [SW-1:0]       pop_sel,
    output logic                live,
    output logic                complete,
    output logic [NSLOT-1:0]    held,
    output hb_out_t [NSLOT-1:0] ents
);
    logic [CW-1:0]        need_q;
    logic                 ex_q;
    logic [HB_IDX_W-1:0]  k_q;

    logic [NSLOT-1:0]     keep, vacant, held_d;
    hb_out_t [NSLOT-1:0]  ents_d;
    logic                 ex_now, ex_eff, in_ok, hit_any, free_any;
    logic [SW-1:0]        hit_s, free_s;
    logic [HB_IDX_W-1:0]  k_eff;
    logic [CW-1:0]        cnt_held;

    assign vacant = ~keep;

    hb_pick_low #(.N(NSLOT)) u_free (
        .req (vacant),
        .any (free_any),
        .sel (free_s)
    );

    always_comb begin
        ex_now = exit_hit && live && !freeze;
        k_eff  = ex_now ? exit_k : k_q;
        ex_eff = ex_now || ex_q;

        // Entries that survive an exit resolving this cycle.
        for (int s = 0; s < NSLOT; s++) begin
            keep[s] = held[s] && !(ex_now && (ents[s].pidx > exit_k));
        end

        in_ok = out_hit && live && !freeze && !(ex_eff && (out_body.pidx > k_eff));

        hit_any = 1'b0;
        hit_s   = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (keep[s] && (ents[s].rnum == out_body.rnum)) begin
                hit_any = 1'b1;
                hit_s   = SW'(s);
            end
        end

        held_d = keep;
        ents_d = ents;
        if (in_ok) begin
            if (hit_any) begin
                if (out_body.pidx > ents[hit_s].pidx) begin
                    ents_d[hit_s] = out_body;
                end
            end else if (free_any) begin
                held_d[free_s] = 1'b1;
                ents_d[free_s] = out_body;
            end
        end
        if (pop) begin
            held_d[pop_sel] = 1'b0;
        end

        cnt_held = '0;
        for (int s = 0; s < NSLOT; s++) begin
            cnt_held = cnt_held + CW'(held[s]);
        end
    end

    assign complete = live && (cnt_held == need_q);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            live   <= 1'b0;
            held   <= '0;
            need_q <= '0;
            ex_q   <= 1'b0;
            k_q    <= '0;
        end else if (alloc) begin
            live   <= 1'b1;
            held   <= '0;
            need_q <= alloc_cnt;
            ex_q   <= 1'b0;
            k_q    <= '0;
        end else if (live) begin
            held <= held_d;
            ents <= ents_d;
            if (ex_now) begin
                ex_q   <= 1'b1;
                k_q    <= exit_k;
                need_q <= exit_cnt;
            end
        end
    end
endmodule

// File: rtl/hb_commit_ctrl.sv
module hb_commit_ctrl import hb_pkg::*; #(
    parameter  int NFRAMES = HB_FRAMES,
    parameter  int NSLOT   = HB_SLOTS,
    localparam int FID_W   = $clog2(NFRAMES),
    localparam int CW      = $clog2(NSLOT + 1),
    localparam int SW      = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 map_valid,
    input  logic [CW-1:0]        map_count,
    output logic                 map_ready,
    output logic [FID_W-1:0]     map_frame,
    input  logic                 out_valid,
    input  logic [FID_W-1:0]     out_frame,
    input  logic [HB_REG_W-1:0]  out_reg,
    input  logic [HB_IDX_W-1:0]  out_idx,
    input  logic [HB_DATA_W-1:0] out_data,
    input  logic                 exit_valid,
    input  logic [FID_W-1:0]     exit_frame,
    input  logic [HB_IDX_W-1:0]  exit_idx,
    input  logic [CW-1:0]        exit_count,
    input  logic                 flush_valid,
    input  logic [FID_W-1:0]     flush_frame,
    output logic                 wr_en,
    output logic [HB_REG_W-1:0]  wr_reg,
    output logic [HB_DATA_W-1:0] wr_data,
    output logic                 done_valid,
    output logic [FID_W-1:0]     done_frame
);
    logic [FID_W-1:0]    head_q, tail_q;
    logic [FID_W:0]      occ_q, occ_n;
    logic                drain_q;

    logic [NFRAMES-1:0]  live_a, cmp_a, squash;
    logic [NSLOT-1:0]    held_a [NFRAMES];
    hb_out_t [NSLOT-1:0] ents_a [NFRAMES];

    hb_out_t             obody;
    logic [NSLOT-1:0]    head_held;
    hb_out_t             head_ent;
    logic                head_nonempty, go, pop_any, release_head, map_acc, flush_ok;
    logic [SW-1:0]       pop_sel;

    function automatic logic [FID_W-1:0] age_of(input logic [FID_W-1:0] fid,
                                                input logic [FID_W-1:0] head);
        return fid - head;
    endfunction

    assign obody     = '{rnum: out_reg, pidx: out_idx, val: out_data};
    assign map_ready = (occ_q < (FID_W + 1)'(NFRAMES));
    assign map_frame = tail_q;
    assign map_acc   = map_valid && map_ready && !flush_valid;
    assign flush_ok  = flush_valid && live_a[flush_frame];

    assign head_held = held_a[head_q];

    hb_pick_low #(.N(NSLOT)) u_drain (
        .req (head_held),
        .any (head_nonempty),
        .sel (pop_sel)
    );

    assign head_ent     = ents_a[head_q][pop_sel];
    assign go           = live_a[head_q] && (drain_q || cmp_a[head_q]);
    assign pop_any      = go && head_nonempty;
    assign release_head = go && !head_nonempty;

    for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
        localparam logic [FID_W-1:0] FID = FID_W'(f);

        assign squash[f] = flush_ok
                        && (age_of(FID, head_q) > age_of(flush_frame, head_q))
                        && ({1'b0, age_of(FID, head_q)} < occ_q);

        hb_frame_buf #(.NSLOT(NSLOT)) u_buf (
            .clk       (clk),
            .rst       (rst),
            .alloc     (map_acc && (tail_q == FID)),
            .alloc_cnt (map_count),
            .kill      ((release_head && (head_q == FID)) || squash[f]),
            .freeze    (go && (head_q == FID)),
            .out_hit   (out_valid && (out_frame == FID)),
            .out_body  (obody),
            .exit_hit  (exit_valid && (exit_frame == FID)),
            .exit_k    (exit_idx),
            .exit_cnt  (exit_count),
            .pop       (pop_any && (head_q == FID)),
            .pop_sel   (pop_sel),
            .live      (live_a[f]),
            .complete  (cmp_a[f]),
            .held      (held_a[f]),
            .ents      (ents_a[f])
        );
    end

    always_comb begin
        if (flush_ok) begin
            occ_n = {1'b0, age_of(flush_frame, head_q)} + (FID_W + 1)'(1);
        end else begin
            occ_n = occ_q + (FID_W + 1)'(map_acc);
        end
        occ_n = occ_n - (FID_W + 1)'(release_head);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            tail_q     <= '0;
            occ_q      <= '0;
            drain_q    <= 1'b0;
            wr_en      <= 1'b0;
            wr_reg     <= '0;
            wr_data    <= '0;
            done_valid <= 1'b0;
            done_frame <= '0;
        end else begin
            head_q  <= head_q + FID_W'(release_head);
            occ_q   <= occ_n;
            drain_q <= pop_any;
            if (flush_ok) begin
                tail_q <= flush_frame + FID_W'(1);
            end else if (map_acc) begin
                tail_q <= tail_q + FID_W'(1);
            end
            wr_en <= pop_any;
            if (pop_any) begin
                wr_reg  <= head_ent.rnum;
                wr_data <= head_ent.val;
            end
            done_valid <= release_head;
            done_frame <= head_q;
        end
    end
endmodule

// File: rtl/hb_commit_chk.sv
module hb_commit_chk #(
    parameter int FID_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             map_valid,
    input logic             map_ready,
    input logic [FID_W-1:0] map_frame,
    input logic             flush_valid,
    input logic             flush_ok,
    input logic [FID_W-1:0] flush_frame,
    input logic             wr_en,
    input logic             done_valid,
    input logic [FID_W-1:0] done_frame
);
    logic [FID_W-1:0] next_done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_done_q <= '0;
        end else if (done_valid) begin
            next_done_q <= next_done_q + FID_W'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_en && !done_valid && map_frame == '0)); // R1

    AST_MAP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (map_valid && map_ready && !flush_valid)
        |=> (map_frame == FID_W'($past(map_frame) + FID_W'(1)))); // R2

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !wr_en); // R5

    AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_frame == next_done_q)); // R6

    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (rst)
        flush_ok |=> (map_frame == FID_W'($past(flush_frame) + FID_W'(1)))); // R10
endmodule

bind hb_commit_ctrl hb_commit_chk #(.FID_W(FID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .map_valid   (map_valid),
    .map_ready   (map_ready),
    .map_frame   (map_frame),
    .flush_valid (flush_valid),
    .flush_ok    (flush_ok),
    .flush_frame (flush_frame),
    .wr_en       (wr_en),
    .done_valid  (done_valid),
    .done_frame  (done_frame)
);

// File: tb/tb_hb_commit_ctrl.sv
module tb_hb_commit_ctrl;
    import hb_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst;
    logic                 map_valid;
    logic [HB_CNT_W-1:0]  map_count;
    logic                 map_ready;
    logic [HB_FID_W-1:0]  map_frame;
    logic                 out_valid;
    logic [HB_FID_W-1:0]  out_frame;
    logic [HB_REG_W-1:0]  out_reg;
    logic [HB_IDX_W-1:0]  out_idx;
    logic [HB_DATA_W-1:0] out_data;
    logic                 exit_valid;
    logic [HB_FID_W-1:0]  exit_frame;
    logic [HB_IDX_W-1:0]  exit_idx;
    logic [HB_CNT_W-1:0]  exit_count;
    logic                 flush_valid;
    logic [HB_FID_W-1:0]  flush_frame;
    logic                 wr_en;
    logic [HB_REG_W-1:0]  wr_reg;
    logic [HB_DATA_W-1:0] wr_data;
    logic                 done_valid;
    logic [HB_FID_W-1:0]  done_frame;

    hb_commit_ctrl dut (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;

    int lreg [256];
    int ldat [256];
    int lcyc [256];
    int nw = 0;
    int dfr [256];
    int dcyc [256];
    int nd = 0;

    always @(negedge clk) begin
        if (!rst && wr_en && nw < 256) begin
            lreg[nw] = int'(wr_reg);
            ldat[nw] = int'(wr_data);
            lcyc[nw] = cyc;
            nw++;
        end
        if (!rst && done_valid && nd < 256) begin
            dfr[nd]  = int'(done_frame);
            dcyc[nd] = cyc;
            nd++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_map(input int cnt);
        map_valid = 1'b1;
        map_count = HB_CNT_W'(cnt);
        @(negedge clk);
        map_valid = 1'b0;
    endtask

    task automatic set_out(input int f, input int r, input int i, input int d);
        out_valid = 1'b1;
        out_frame = HB_FID_W'(f);
        out_reg   = HB_REG_W'(r);
        out_idx   = HB_IDX_W'(i);
        out_data  = HB_DATA_W'(d);
    endtask

    task automatic put_out(input int f, input int r, input int i, input int d);
        set_out(f, r, i, d);
        @(negedge clk);
        out_valid = 1'b0;
    endtask

    task automatic set_exit(input int f, input int k, input int c);
        exit_valid = 1'b1;
        exit_frame = HB_FID_W'(f);
        exit_idx   = HB_IDX_W'(k);
        exit_count = HB_CNT_W'(c);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        summary();
        $finish;
    end

    initial begin
        int w0, d0, c, fa, fb, h;
        rst = 1'b1;
        map_valid = 0; map_count = '0;
        out_valid = 0; out_frame = '0; out_reg = '0; out_idx = '0; out_data = '0;
        exit_valid = 0; exit_frame = '0; exit_idx = '0; exit_count = '0;
        flush_valid = 0; flush_frame = '0;
        idle(3);
        // R1: reset state
        eq("R1", "wr_en", int'(wr_en), 0);
        eq("R1", "done_valid", int'(done_valid), 0);
        eq("R1", "map_ready", int'(map_ready), 1);
        eq("R1", "map_frame", int'(map_frame), 0);
        rst = 1'b0;
        idle(1);
        eq("R1", "wr_en after release", int'(wr_en), 0);

        // Sweep of expected counts 0..4: R2, R3, R4, R5
        for (int n = 0; n <= 4; n++) begin
            w0 = nw; d0 = nd;
            fa = int'(map_frame);
            eq("R2", "frame number", fa, n % 4);
            c = cyc;
            do_map(n);
            for (int j = 0; j < n; j++) begin
                eq("R3", "no write before complete", nw - w0, 0);
                c = cyc;
                put_out(fa, n * 4 + j, j, 32'hA000 + n * 16 + j);
            end
            idle(n + 5);
            eq("R4", "write count", nw - w0, n);
            for (int j = 0; j < n; j++) begin
                eq("R4", "write reg order", lreg[w0 + j], n * 4 + j);
                eq("R4", "write data", ldat[w0 + j], 32'hA000 + n * 16 + j);
                eq("R3", "write cycle", lcyc[w0 + j], c + 2 + j);
            end
            eq("R5", "done count", nd - d0, 1);
            eq("R5", "done frame", dfr[d0], fa);
            eq("R5", "done cycle", dcyc[d0], c + 2 + n);
        end

        // R6: younger block completes first but waits
        w0 = nw; d0 = nd;
        fa = int'(map_frame); do_map(2);
        fb = int'(map_frame); do_map(1);
        put_out(fb, 20, 0, 32'hB0);
        idle(5);
        eq("R6", "younger held back", nw - w0, 0);
        put_out(fa, 21, 0, 32'hA1);
        put_out(fa, 22, 1, 32'hA2);
        idle(8);
        eq("R6", "write count", nw - w0, 3);
        eq("R6", "first write", lreg[w0], 21);
        eq("R6", "second write", lreg[w0 + 1], 22);
        eq("R6", "third write", lreg[w0 + 2], 20);
        eq("R6", "done count", nd - d0, 2);
        eq("R6", "older done first", dfr[d0], fa);
        eq("R6", "younger done second", dfr[d0 + 1], fb);

        // R7: duplicates
        w0 = nw;
        fa = int'(map_frame); do_map(2);
        put_out(fa, 3, 4, 1);
        put_out(fa, 3, 2, 2);
        put_out(fa, 3, 6, 3);
        idle(3);
        eq("R7", "duplicates do not complete", nw - w0, 0);
        put_out(fa, 7, 1, 4);
        idle(6);
        eq("R7", "write count", nw - w0, 2);
        eq("R7", "reg kept", lreg[w0], 3);
        eq("R7", "newest index wins", ldat[w0], 3);
        eq("R7", "second reg", lreg[w0 + 1], 7);

        // R8: exit filters held and later results
        w0 = nw;
        fa = int'(map_frame); do_map(3);
        put_out(fa, 1, 2, 11);
        put_out(fa, 2, 9, 12);
        set_exit(fa, 5, 2); @(negedge clk); exit_valid = 1'b0;
        put_out(fa, 3, 7, 13);
        idle(4);
        eq("R8", "late result dropped", nw - w0, 0);
        put_out(fa, 4, 3, 14);
        idle(6);
        eq("R8", "write count", nw - w0, 2);
        eq("R8", "first reg", lreg[w0], 1);
        eq("R8", "second reg", lreg[w0 + 1], 4);
        eq("R8", "second data", ldat[w0 + 1], 14);

        // R9: result and exit in the same cycle, past the cut-off
        w0 = nw;
        fa = int'(map_frame); do_map(3);
        put_out(fa, 1, 1, 21);
        set_exit(fa, 4, 2); set_out(fa, 2, 6, 22);
        @(negedge clk); exit_valid = 1'b0; out_valid = 1'b0;
        idle(4);
        eq("R9", "same-cycle late result dropped", nw - w0, 0);
        put_out(fa, 5, 3, 23);
        idle(6);
        eq("R9", "write count", nw - w0, 2);
        eq("R9", "first reg", lreg[w0], 1);
        eq("R9", "second reg", lreg[w0 + 1], 5);

        // R9: same cycle, before the cut-off
        w0 = nw;
        fa = int'(map_frame); do_map(3);
        c = cyc;
        set_exit(fa, 4, 1); set_out(fa, 6, 2, 24);
        @(negedge clk); exit_valid = 1'b0; out_valid = 1'b0;
        idle(5);
        eq("R9", "early result kept", nw - w0, 1);
        eq("R9", "kept data", ldat[w0], 24);
        eq("R9", "write cycle", lcyc[w0], c + 2);

        // R2, R10, R11: fill, reject, flush
        w0 = nw; d0 = nd;
        h = int'(map_frame);
        for (int j = 0; j < 4; j++) begin
            eq("R2", "circular frame", int'(map_frame), (h + j) % 4);
            do_map(1);
        end
        eq("R2", "full not ready", int'(map_ready), 0);
        do_map(1);
        eq("R2", "full map ignored", int'(map_frame), h);
        flush_valid = 1'b1; flush_frame = HB_FID_W'(h);
        map_valid = 1'b1; map_count = HB_CNT_W'(1);
        @(negedge clk);
        flush_valid = 1'b0; map_valid = 1'b0;
        eq("R10", "tail after flush", int'(map_frame), (h + 1) % 4);
        eq("R10", "ready after flush", int'(map_ready), 1);
        put_out((h + 1) % 4, 9, 0, 32'hDEAD);
        put_out((h + 2) % 4, 9, 0, 32'hBEEF);
        put_out(h, 8, 0, 31);
        idle(6);
        eq("R10", "only survivor writes", nw - w0, 1);
        eq("R10", "survivor data", ldat[w0], 31);
        eq("R10", "one done", nd - d0, 1);
        eq("R10", "done frame", dfr[d0], h);
        fa = int'(map_frame);
        eq("R11", "reused frame", fa, (h + 1) % 4);
        do_map(1);
        idle(4);
        eq("R11", "stale result ignored", nw - w0, 1);
        put_out(fa, 10, 0, 32);
        idle(5);
        eq("R11", "write count", nw - w0, 2);
        eq("R11", "fresh data", ldat[w0 + 1], 32);
        eq("R11", "done frame", dfr[d0 + 1], fa);

        summary();
        $finish;
    end
endmodule